// File: doc/BRIEF.md
# Priority Interrupt Acceptance Unit

This block is the per-processor end of an interrupt controller. It keeps three vectors with one bit per interrupt vector: pending requests, requests in service, and the trigger mode of each vector. Each cycle it works out whether the best waiting request may interrupt the processor. The processor acknowledges an interrupt to move the request into service, and signals end-of-interrupt to retire the most urgent vector in service. Only the per-vector bookkeeping and the priority arithmetic are here. Register access, message routing and the non-maskable side channels sit outside.

Priority goes with the vector number. The class of a vector is its bits 7:4. The processor priority is the larger of two values: the programmed task priority, and the class of the top vector in service. A request is offered only when its class beats the processor priority, or when the processor priority is zero. Level-triggered vectors announce their end-of-interrupt on a broadcast strobe, which lets upstream sources re-arm. That broadcast can be turned off.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset the task priority is 0, the control word is 0x0FF (enable bit 8 clear), and the request, in-service and trigger vectors are empty. So `irq_pending` is 0, `ppr` is 0, `eoi_bcast` is 0, and an acknowledge gives `ack_valid` = 0.
- R2: Among several requests, the highest-numbered vector is the one offered and acknowledged first.
- R3: When bits 7:4 of the task priority are at least the class of the top in-service vector, `ppr` equals the task priority. Otherwise `ppr` equals that class shifted left by 4. An empty in-service set counts as class 0.
- R4: `irq_pending` is 1 only when the top request's class (bits 7:4) is above the class of `ppr`, or `ppr` is zero, and the unit is enabled.
- R5: An acknowledge of a deliverable request returns its vector with `ack_valid` = 1. In the same edge it clears the request bit and sets the in-service bit.
- R6: An acknowledge of a request blocked by priority returns `ack_valid` = 1 with the spurious vector (control bits 7:0). It changes no state.
- R7: An acknowledge with no request pending returns `ack_valid` = 0 and changes no state.
- R8: A request sets the trigger bit of its vector when `req_level` = 1 and clears it when `req_level` = 0. The last request to a vector decides its trigger mode.
- R9: End-of-interrupt clears the highest in-service bit, which lowers `ppr` to match. With an empty in-service set it does nothing.
- R10: One cycle after an end-of-interrupt, `eoi_bcast` pulses with `eoi_vector` = the retired vector. This happens only if that vector's trigger bit is set and control bit 12 (directed mode) is clear.
- R11: While control bit 8 is clear, `irq_pending` is 0 and an acknowledge returns `ack_valid` = 0 and changes nothing. Requests are still recorded and get offered once the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Record a request this cycle |
| req_vector | input | 8 | Vector of the request |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr_we | input | 1 | Write the task priority |
| tpr_wdata | input | 8 | New task priority |
| ctl_we | input | 1 | Write the control word |
| ctl_wdata | input | 13 | Bits 7:0 spurious vector, bit 8 enable, bit 12 directed end-of-interrupt |
| ack | input | 1 | Acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_pending | output | 1 | A deliverable request is waiting |
| ack_valid | output | 1 | Acknowledge this cycle returns a vector |
| ack_vector | output | 8 | Vector returned to the acknowledge |
| ppr | output | 8 | Processor priority |
| eoi_bcast | output | 1 | End-of-interrupt broadcast pulse |
| eoi_vector | output | 8 | Vector carried by the broadcast |

## Verification
On every cycle the assertions check four things: pending never rises while the unit is disabled, `ppr` never falls below the task priority, an accepted acknowledge always lands in service, and a priority-blocked acknowledge returns the spurious vector and leaves the in-service set alone. They also check that each request's trigger mode is written, and that every broadcast traces back to an end-of-interrupt taken outside directed mode. Other behaviour needs the bench's scenarios. These include the order in which stacked requests come out, the fall of `ppr` as nested services retire, the sweep across every vector and every pairing of task-priority class with request class, and held requests that reappear after re-enabling or after lowering the task priority.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int CTL_W        = 13;
  localparam int CTL_EN_BIT   = 8;
  localparam int CTL_DEOI_BIT = 12;
  localparam int CLASS_LSB    = 4;
endpackage

// File: rtl/irq_msb_find.sv
module irq_msb_find #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Ascending scan: the last set bit seen is the highest-numbered one.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_calc.sv
module irq_prio_calc import irq_accept_pkg::*; #(
  parameter int VW = 8
) (
  input  logic [VW-1:0] tpr,
  input  logic          svc_found,
  input  logic [VW-1:0] svc_top,
  input  logic          req_found,
  input  logic [VW-1:0] req_top,
  output logic [VW-1:0] ppr,
  output logic          deliverable
);
  localparam int CW = VW - CLASS_LSB;

  function automatic logic [CW-1:0] class_of(input logic [VW-1:0] v);
    return v[VW-1:CLASS_LSB];
  endfunction

  logic [CW-1:0] svc_class;

  always_comb begin
    svc_class = svc_found ? class_of(svc_top) : '0;
    if (class_of(tpr) >= svc_class) ppr = tpr;
    else                            ppr = {svc_class, {CLASS_LSB{1'b0}}};
    deliverable = req_found &&
                  ((ppr == '0) || (class_of(req_top) > class_of(ppr)));
  end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit import irq_accept_pkg::*; #(
  parameter int NUM_VEC = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [$clog2(NUM_VEC)-1:0] req_vector,
  input  logic                       req_level,
  input  logic                       tpr_we,
  input  logic [$clog2(NUM_VEC)-1:0] tpr_wdata,
  input  logic                       ctl_we,
  input  logic [CTL_W-1:0]           ctl_wdata,
  input  logic                       ack,
  input  logic                       eoi,
  output logic                       irq_pending,
  output logic                       ack_valid,
  output logic [$clog2(NUM_VEC)-1:0] ack_vector,
  output logic [$clog2(NUM_VEC)-1:0] ppr,
  output logic                       eoi_bcast,
  output logic [$clog2(NUM_VEC)-1:0] eoi_vector
);
  localparam int VW = $clog2(NUM_VEC);
  localparam logic [CTL_W-1:0] CTL_RESET = CTL_W'(8'hFF);

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [VW-1:0]      tpr_q;
  logic [CTL_W-1:0]   ctl_q;

  // Named internal events, brought out for the checker.
  logic          irr_found, isr_found, deliverable;
  logic [VW-1:0] irr_top, isr_top;
  logic          sw_en, ack_take, ack_spur, eoi_fire, eoi_level;

  irq_msb_find #(.N(NUM_VEC), .IW(VW)) u_find_req (
    .bits(irr_q), .found(irr_found), .idx(irr_top));
  irq_msb_find #(.N(NUM_VEC), .IW(VW)) u_find_svc (
    .bits(isr_q), .found(isr_found), .idx(isr_top));

  irq_prio_calc #(.VW(VW)) u_prio (
    .tpr(tpr_q), .svc_found(isr_found), .svc_top(isr_top),
    .req_found(irr_found), .req_top(irr_top),
    .ppr(ppr), .deliverable(deliverable));

  assign sw_en     = ctl_q[CTL_EN_BIT];
  assign ack_take  = ack && sw_en && deliverable;
  assign ack_spur  = ack && sw_en && irr_found && !deliverable;
  assign eoi_fire  = eoi && isr_found;
  assign eoi_level = eoi_fire && tmr_q[isr_top] && !ctl_q[CTL_DEOI_BIT];

  assign irq_pending = sw_en && deliverable;
  assign ack_valid   = ack_take || ack_spur;
  assign ack_vector  = ack_take ? irr_top :
                       ack_spur ? ctl_q[VW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q      <= '0;
      isr_q      <= '0;
      tmr_q      <= '0;
      tpr_q      <= '0;
      ctl_q      <= CTL_RESET;
      eoi_bcast  <= 1'b0;
      eoi_vector <= '0;
    end else begin
      if (ack_take)  irr_q[irr_top] <= 1'b0;
      if (req_valid) begin
        irr_q[req_vector] <= 1'b1;
        tmr_q[req_vector] <= req_level;
      end
      if (eoi_fire)  isr_q[isr_top] <= 1'b0;
      if (ack_take)  isr_q[irr_top] <= 1'b1;
      if (tpr_we)    tpr_q <= tpr_wdata;
      if (ctl_we)    ctl_q <= ctl_wdata;
      eoi_bcast  <= eoi_level;
      eoi_vector <= eoi_level ? isr_top : '0;
    end
  end
endmodule

// File: rtl/irq_accept_checker.sv
module irq_accept_checker import irq_accept_pkg::*; #(
  parameter int NUM_VEC = 256,
  parameter int VW = $clog2(NUM_VEC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [VW-1:0]      req_vector,
  input logic               req_level,
  input logic               ack,
  input logic               eoi,
  input logic               irq_pending,
  input logic               ack_valid,
  input logic [VW-1:0]      ack_vector,
  input logic [VW-1:0]      ppr,
  input logic               eoi_bcast,
  input logic [VW-1:0]      tpr_q,
  input logic [CTL_W-1:0]   ctl_q,
  input logic [NUM_VEC-1:0] isr_q,
  input logic [NUM_VEC-1:0] tmr_q
);
  assert_pend_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> ctl_q[CTL_EN_BIT]);

  assert_ppr_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ppr >= tpr_q);

  assert_ack_to_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_pending) |=> isr_q[$past(ack_vector)]);

  assert_spur_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_valid && !irq_pending) |-> ack_vector == ctl_q[VW-1:0]);

  assert_spur_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_valid && !irq_pending && !eoi) |=> $stable(isr_q));

  assert_trig_written_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> tmr_q[$past(req_vector)] == $past(req_level));

  assert_bcast_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast |-> ($past(eoi) && !$past(ctl_q[CTL_DEOI_BIT])));
endmodule

bind irq_accept_unit irq_accept_checker #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
  .req_level(req_level), .ack(ack), .eoi(eoi), .irq_pending(irq_pending),
  .ack_valid(ack_valid), .ack_vector(ack_vector), .ppr(ppr),
  .eoi_bcast(eoi_bcast), .tpr_q(tpr_q), .ctl_q(ctl_q), .isr_q(isr_q),
  .tmr_q(tmr_q));

// File: tb/irq_accept_unit_tb.sv
`timescale 1ns/1ps
module irq_accept_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_level = 1'b0;
  logic [7:0]  req_vector = '0;
  logic        tpr_we = 1'b0;
  logic [7:0]  tpr_wdata = '0;
  logic        ctl_we = 1'b0;
  logic [12:0] ctl_wdata = '0;
  logic        ack = 1'b0, eoi = 1'b0;
  logic        irq_pending, ack_valid, eoi_bcast;
  logic [7:0]  ack_vector, ppr, eoi_vector;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_accept_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
    .req_level(req_level), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ack(ack), .eoi(eoi),
    .irq_pending(irq_pending), .ack_valid(ack_valid), .ack_vector(ack_vector),
    .ppr(ppr), .eoi_bcast(eoi_bcast), .eoi_vector(eoi_vector));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic send_req(input logic [7:0] v, input logic lvl);
    req_valid = 1'b1; req_vector = v; req_level = lvl;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic set_tpr(input logic [7:0] t);
    tpr_we = 1'b1; tpr_wdata = t;
    @(negedge clk); tpr_we = 1'b0;
  endtask

  task automatic set_ctl(input logic [12:0] c);
    ctl_we = 1'b1; ctl_wdata = c;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic do_ack(output logic ok, output logic [7:0] v);
    ack = 1'b1; #1; ok = ack_valid; v = ack_vector;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_eoi(output logic bc, output logic [7:0] bv);
    eoi = 1'b1;
    @(negedge clk); eoi = 1'b0; bc = eoi_bcast; bv = eoi_vector;
  endtask

  function automatic logic [7:0] exp_ppr(input logic [7:0] t, input logic [7:0] top_svc);
    return (t[7:4] >= top_svc[7:4]) ? t : {top_svc[7:4], 4'h0};
  endfunction

  task automatic ack_expect(input logic [7:0] v, input string tag);
    logic ok; logic [7:0] got;
    do_ack(ok, got);
    chk(ok == 1'b1, tag, ok, 1);
    chk(got == v, tag, got, v);
  endtask

  task automatic eoi_expect(input logic bc_exp, input logic [7:0] v, input string tag);
    logic bc; logic [7:0] bv;
    do_eoi(bc, bv);
    chk(bc == bc_exp, tag, bc, bc_exp);
    if (bc_exp) chk(bv == v, tag, bv, v);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic ok; logic [7:0] got; logic bc; logic [7:0] bv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(irq_pending == 1'b0, "R1 pending", irq_pending, 0);
    chk(ppr == 8'h00, "R1 ppr", ppr, 0);
    chk(eoi_bcast == 1'b0, "R1 bcast", eoi_bcast, 0);
    do_ack(ok, got);
    chk(ok == 1'b0, "R1 ack none", ok, 0);

    // R11: disabled unit records but does not offer
    send_req(8'h50, 1'b0);
    chk(irq_pending == 1'b0, "R11 pending while disabled", irq_pending, 0);
    do_ack(ok, got);
    chk(ok == 1'b0, "R11 ack while disabled", ok, 0);
    set_ctl(13'h1FF);
    chk(irq_pending == 1'b1, "R11 pending after enable", irq_pending, 1);
    ack_expect(8'h50, "R11 held request");
    eoi_expect(1'b0, 8'h00, "R10 edge no bcast");

    // R7: empty acknowledge; R9 empty eoi
    do_ack(ok, got);
    chk(ok == 1'b0, "R7 ack empty", ok, 0);
    chk(ppr == 8'h00, "R7 ppr unchanged", ppr, 0);
    eoi_expect(1'b0, 8'h00, "R9 eoi empty");

    // Sweep every vector with ppr 0: R2 R3 R4 R5 R9 R10 R8
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vv;
      vv = 8'(v);
      send_req(vv, vv[0]);
      chk(irq_pending == 1'b1, "R4 sweep pending", irq_pending, 1);
      ack_expect(vv, "R5 sweep ack");
      chk(ppr == exp_ppr(8'h00, vv), "R3 sweep ppr", ppr, exp_ppr(8'h00, vv));
      chk(irq_pending == 1'b0, "R5 sweep consumed", irq_pending, 0);
      eoi_expect(vv[0], vv, "R10 sweep bcast");
      chk(ppr == 8'h00, "R9 sweep ppr back", ppr, 0);
    end

    // Task priority class against request class: R4 R6
    set_ctl(13'h1EF);
    for (int t = 0; t < 16; t++) begin
      for (int c = 0; c < 16; c++) begin
        logic [7:0] tp, rv;
        logic deliv;
        tp = 8'(t * 16 + (c % 3));
        rv = 8'(c * 16 + 9);
        deliv = (tp == 8'h00) || (c > t);
        set_tpr(tp);
        chk(ppr == tp, "R3 ppr equals tpr", ppr, tp);
        send_req(rv, 1'b1);
        chk(irq_pending == deliv, "R4 class gate", irq_pending, deliv);
        if (deliv) begin
          ack_expect(rv, "R5 class ack");
        end else begin
          ack_expect(8'hEF, "R6 spurious");
          chk(ppr == tp, "R6 ppr unchanged", ppr, tp);
          chk(irq_pending == 1'b0, "R6 still blocked", irq_pending, 0);
          set_tpr(8'h00);
          ack_expect(rv, "R6 request kept");
        end
        eoi_expect(1'b1, rv, "R10 level bcast");
      end
    end
    set_tpr(8'h00);
    set_ctl(13'h1FF);

    // Nesting: R3 R4 R6 R9
    send_req(8'h30, 1'b0);
    ack_expect(8'h30, "R5 nest first");
    chk(ppr == 8'h30, "R3 nest ppr", ppr, 8'h30);
    send_req(8'h35, 1'b0);
    chk(irq_pending == 1'b0, "R4 equal class blocked", irq_pending, 0);
    ack_expect(8'hFF, "R6 equal class spurious");
    send_req(8'h80, 1'b0);
    chk(irq_pending == 1'b1, "R4 higher class preempts", irq_pending, 1);
    ack_expect(8'h80, "R2 nest second");
    chk(ppr == 8'h80, "R3 nest ppr high", ppr, 8'h80);
    eoi_expect(1'b0, 8'h00, "R9 eoi top");
    chk(ppr == 8'h30, "R9 ppr falls", ppr, 8'h30);
    eoi_expect(1'b0, 8'h00, "R9 eoi next");
    chk(ppr == 8'h00, "R9 ppr zero", ppr, 0);
    chk(irq_pending == 1'b1, "R4 blocked now offered", irq_pending, 1);
    ack_expect(8'h35, "R6 blocked request kept");
    eoi_expect(1'b0, 8'h00, "R9 clear");

    // Ordering of stacked requests: R2
    send_req(8'h41, 1'b1);
    send_req(8'h47, 1'b0);
    send_req(8'h90, 1'b0);
    ack_expect(8'h90, "R2 order 1");
    eoi_expect(1'b0, 8'h00, "R10 order 1");
    ack_expect(8'h47, "R2 order 2");
    eoi_expect(1'b0, 8'h00, "R10 order 2");
    ack_expect(8'h41, "R2 order 3");
    eoi_expect(1'b1, 8'h41, "R10 order 3 level");

    // Last trigger mode wins: R8
    send_req(8'h66, 1'b1);
    send_req(8'h66, 1'b0);
    ack_expect(8'h66, "R8 retrigger ack");
    eoi_expect(1'b0, 8'h00, "R8 edge overrides level");
    send_req(8'h67, 1'b0);
    send_req(8'h67, 1'b1);
    ack_expect(8'h67, "R8 retrigger ack 2");
    eoi_expect(1'b1, 8'h67, "R8 level overrides edge");

    // Directed mode suppresses broadcast: R10
    set_ctl(13'h11FF);
    send_req(8'h70, 1'b1);
    ack_expect(8'h70, "R10 directed ack");
    eoi_expect(1'b0, 8'h00, "R10 directed no bcast");
    chk(ppr == 8'h00, "R9 directed still retires", ppr, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule